// File: doc/BRIEF.md
# Codec Register Access Engine

This block lets a host read and write single registers in any of three serial audio/modem codecs attached to a frame-based link. The host writes one 32-bit command word. That word packs the codec select, the transfer direction, an enable flag, the register address and the write data. The enable flag reads back as a busy indication. While it is set, the engine is waiting for the next frame-start strobe. On that strobe the engine presents the command on abstract slot outputs (an address slot and a data slot) for one cycle, and the busy flag drops in the same cycle.

For reads, the engine then watches the status slots coming back from the codecs. It captures the reply whose codec and address match the request into a separate response word, which carries a completion flag. If no matching reply arrives within a programmable number of frames, the engine completes the read itself. It returns all-ones data and raises a sticky timeout status bit.

A status word also mirrors one not-ready indication per codec. Serialisation of the link, power management and bulk data movement belong to other blocks.

Top module: `codec_cmd_engine`

## Requirements
- R1: After reset the busy flag (command word bit 8), the completion flag (response word bit 8), the timeout status bit (status bit 15) and `tx_valid` are all 0.
- R2: A host write with bit 8 set, codec select bits [1:0] in 0..2, and no command pending makes busy read 1 from the next cycle. The command readback then shows codec in [1:0], direction in bit 2 (1 = read, 0 = write), address in [15:9] and data in [31:16], with bits [7:3] zero.
- R3: A frame-start strobe sampled while busy produces a one-cycle `tx_valid` pulse in the next cycle, carrying the stored codec, direction, address and data. For reads the data slot is zero. Busy reads 0 in that same cycle.
- R4: A host write while busy is set leaves the command readback unchanged and does not alter the command that is later issued.
- R5: For an issued read, a reply with matching codec and address sets the response word: bit 8 = 1, address in [15:9], reply data in [31:16]. The response is visible in the cycle after the reply is sampled.
- R6: A reply whose codec or address differs from the pending read is ignored and leaves the completion flag at 0.
- R7: If a read sees `tmo_frames` frame strobes after its issue strobe with no match, the completion flag is set with data 16'hFFFF and the requested address, and status bit 15 is set. A limit of 0 acts as 1.
- R8: Accepting a new command clears the completion flag and the timeout status bit.
- R9: Status bits 10, 11 and 12 report codecs 0, 1 and 2 as not ready. Each is the inverse of its `codec_ready` input, delayed by one cycle.
- R10: A write with codec select 3, or with bit 8 clear, launches nothing and leaves the command readback unchanged.
- R11: An issued write command does not set the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_data | input | 32 | Command word being written |
| tmo_frames | input | TMO_W | Reply timeout in frames (0 treated as 1) |
| cmd_rd_data | output | 32 | Command word readback, bit 8 = busy |
| rsp_rd_data | output | 32 | Response word, bit 8 = read complete |
| stat_word | output | 16 | Bits 12:10 codec not ready, bit 15 timeout |
| frame_start | input | 1 | One-cycle frame-start strobe |
| tx_valid | output | 1 | Slot outputs carry a command this cycle |
| tx_codec | output | 2 | Target codec of the issued command |
| tx_read | output | 1 | Issued command is a read |
| tx_addr | output | 7 | Command-address slot content |
| tx_data | output | 16 | Command-data slot content (zero for reads) |
| rx_valid | input | 1 | Status-slot reply present |
| rx_codec | input | 2 | Codec that sent the reply |
| rx_addr | input | 7 | Status address slot of the reply |
| rx_data | input | 16 | Status data slot of the reply |
| codec_ready | input | 3 | Per-codec ready indication |

## Verification
The bench builds the engine with `TMO_W` = 4, so the full range of reply limits, including the zero-means-one case, can be reached in a few frames. With limits of 1 to 4, timeouts happen often enough to mix with matched replies in the random phase. A smaller counter width changes none of the slot or response behaviour, so the short runs stand in for the default width.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
    localparam int SEL_W       = 2;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 16;
    localparam int NUM_CODECS  = 3;
    localparam int DIR_BIT     = 2;
    localparam int BUSY_BIT    = 8;
    localparam int ADDR_LSB    = 9;
    localparam int DATA_LSB    = 16;
    localparam int NRDY_LSB    = 10;
    localparam int TMO_BIT     = 15;
    localparam logic [DATA_W-1:0] TMO_FILL = '1;

    typedef struct packed {
        logic [SEL_W-1:0]  codec;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ccx_cmd_t;

    typedef struct packed {
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ccx_rsp_t;

    function automatic ccx_cmd_t unpack_cmd(input logic [31:0] w);
        ccx_cmd_t c;
        c.codec = w[SEL_W-1:0];
        c.rd    = w[DIR_BIT];
        c.addr  = w[ADDR_LSB +: ADDR_W];
        c.data  = w[DATA_LSB +: DATA_W];
        return c;
    endfunction

    function automatic logic launch_request(input logic [31:0] w);
        return w[BUSY_BIT] && (int'(w[SEL_W-1:0]) < NUM_CODECS);
    endfunction

    function automatic logic [31:0] pack_cmd(input ccx_cmd_t c, input logic busy);
        logic [31:0] w;
        w = '0;
        w[SEL_W-1:0]         = c.codec;
        w[DIR_BIT]           = c.rd;
        w[BUSY_BIT]          = busy;
        w[ADDR_LSB +: ADDR_W] = c.addr;
        w[DATA_LSB +: DATA_W] = c.data;
        return w;
    endfunction

    function automatic logic [31:0] pack_rsp(input ccx_rsp_t r);
        logic [31:0] w;
        w = '0;
        w[BUSY_BIT]           = r.done;
        w[ADDR_LSB +: ADDR_W] = r.addr;
        w[DATA_LSB +: DATA_W] = r.data;
        return w;
    endfunction
endpackage

// File: rtl/ccx_cmd_reg.sv
module ccx_cmd_reg
    import ccx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    input  logic        frame_start,
    output ccx_cmd_t    cmd,
    output logic        busy,
    output logic        launch,
    output logic        issue
);
    ccx_cmd_t cmd_q;
    logic     busy_q;

    assign launch = wr_en && !busy_q && launch_request(wr_word);
    assign issue  = busy_q && frame_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
        end else if (launch) begin
            cmd_q  <= unpack_cmd(wr_word);
            busy_q <= 1'b1;
        end else if (issue) begin
            busy_q <= 1'b0;
        end
    end

    assign cmd  = cmd_q;
    assign busy = busy_q;
endmodule

// File: rtl/ccx_slot_drive.sv
module ccx_slot_drive
    import ccx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  ccx_cmd_t          cmd,
    output logic              tx_valid,
    output logic [SEL_W-1:0]  tx_codec,
    output logic              tx_read,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_codec <= '0;
            tx_read  <= 1'b0;
            tx_addr  <= '0;
            tx_data  <= '0;
        end else begin
            tx_valid <= issue;
            if (issue) begin
                tx_codec <= cmd.codec;
                tx_read  <= cmd.rd;
                tx_addr  <= cmd.addr;
                tx_data  <= cmd.rd ? '0 : cmd.data;
            end
        end
    end
endmodule

// File: rtl/ccx_reply_track.sv
module ccx_reply_track
    import ccx_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              issue,
    input  logic              req_rd,
    input  logic [SEL_W-1:0]  req_codec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              frame_start,
    input  logic              rx_valid,
    input  logic [SEL_W-1:0]  rx_codec,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [TMO_W-1:0]  tmo_frames,
    output ccx_rsp_t          rsp,
    output logic              timed_out
);
    localparam int CNT_W = TMO_W + 1;

    logic              pending_q;
    logic [SEL_W-1:0]  want_codec_q;
    logic [ADDR_W-1:0] want_addr_q;
    logic [CNT_W-1:0]  frames_q;
    logic [CNT_W-1:0]  limit_eff;
    logic              hit;
    logic              expire;
    ccx_rsp_t          rsp_q;
    logic              tmo_q;

    assign limit_eff = (tmo_frames == '0) ? CNT_W'(1) : {1'b0, tmo_frames};
    assign hit       = pending_q && rx_valid &&
                       (rx_codec == want_codec_q) && (rx_addr == want_addr_q);
    assign expire    = pending_q && !hit && frame_start &&
                       ((frames_q + CNT_W'(1)) >= limit_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q    <= 1'b0;
            want_codec_q <= '0;
            want_addr_q  <= '0;
            frames_q     <= '0;
            rsp_q        <= '0;
            tmo_q        <= 1'b0;
        end else if (launch) begin
            pending_q <= 1'b0;
            rsp_q     <= '0;
            tmo_q     <= 1'b0;
        end else if (issue) begin
            pending_q    <= req_rd;
            want_codec_q <= req_codec;
            want_addr_q  <= req_addr;
            frames_q     <= '0;
        end else if (hit) begin
            pending_q  <= 1'b0;
            rsp_q.done <= 1'b1;
            rsp_q.addr <= rx_addr;
            rsp_q.data <= rx_data;
        end else if (expire) begin
            pending_q  <= 1'b0;
            rsp_q.done <= 1'b1;
            rsp_q.addr <= want_addr_q;
            rsp_q.data <= TMO_FILL;
            tmo_q      <= 1'b1;
        end else if (pending_q && frame_start) begin
            frames_q <= frames_q + CNT_W'(1);
        end
    end

    assign rsp       = rsp_q;
    assign timed_out = tmo_q;
endmodule

// File: rtl/ccx_status.sv
module ccx_status
    import ccx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CODECS-1:0] codec_ready,
    output logic [NUM_CODECS-1:0] not_ready
);
    for (genvar i = 0; i < NUM_CODECS; i++) begin : g_nrdy
        always_ff @(posedge clk) begin
            if (rst) not_ready[i] <= 1'b0;
            else     not_ready[i] <= ~codec_ready[i];
        end
    end
endmodule

// File: rtl/codec_cmd_engine.sv
module codec_cmd_engine
    import ccx_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr_en,
    input  logic [31:0]           host_wr_data,
    input  logic [TMO_W-1:0]      tmo_frames,
    output logic [31:0]           cmd_rd_data,
    output logic [31:0]           rsp_rd_data,
    output logic [15:0]           stat_word,
    input  logic                  frame_start,
    output logic                  tx_valid,
    output logic [SEL_W-1:0]      tx_codec,
    output logic                  tx_read,
    output logic [ADDR_W-1:0]     tx_addr,
    output logic [DATA_W-1:0]     tx_data,
    input  logic                  rx_valid,
    input  logic [SEL_W-1:0]      rx_codec,
    input  logic [ADDR_W-1:0]     rx_addr,
    input  logic [DATA_W-1:0]     rx_data,
    input  logic [NUM_CODECS-1:0] codec_ready
);
    ccx_cmd_t              cmd;
    logic                  busy;
    logic                  launch;
    logic                  issue;
    ccx_rsp_t              rsp;
    logic                  timed_out;
    logic [NUM_CODECS-1:0] not_ready;

    ccx_cmd_reg u_cmd (
        .clk(clk), .rst(rst), .wr_en(host_wr_en), .wr_word(host_wr_data),
        .frame_start(frame_start), .cmd(cmd), .busy(busy),
        .launch(launch), .issue(issue)
    );

    ccx_slot_drive u_slot (
        .clk(clk), .rst(rst), .issue(issue), .cmd(cmd),
        .tx_valid(tx_valid), .tx_codec(tx_codec), .tx_read(tx_read),
        .tx_addr(tx_addr), .tx_data(tx_data)
    );

    ccx_reply_track #(.TMO_W(TMO_W)) u_reply (
        .clk(clk), .rst(rst), .launch(launch), .issue(issue),
        .req_rd(cmd.rd), .req_codec(cmd.codec), .req_addr(cmd.addr),
        .frame_start(frame_start), .rx_valid(rx_valid), .rx_codec(rx_codec),
        .rx_addr(rx_addr), .rx_data(rx_data), .tmo_frames(tmo_frames),
        .rsp(rsp), .timed_out(timed_out)
    );

    ccx_status u_stat (
        .clk(clk), .rst(rst), .codec_ready(codec_ready), .not_ready(not_ready)
    );

    logic unused_data;
    assign unused_data = ^cmd.data;

    assign cmd_rd_data = pack_cmd(cmd, busy);
    assign rsp_rd_data = pack_rsp(rsp);

    always_comb begin
        stat_word = '0;
        stat_word[NRDY_LSB +: NUM_CODECS] = not_ready;
        stat_word[TMO_BIT] = timed_out;
    end
endmodule

// File: rtl/ccx_checker.sv
module ccx_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_wr_en,
    input logic [31:0] host_wr_data,
    input logic [31:0] cmd_rd_data,
    input logic [31:0] rsp_rd_data,
    input logic [15:0] stat_word,
    input logic        frame_start,
    input logic        tx_valid,
    input logic        tx_read,
    input logic [15:0] tx_data,
    input logic [2:0]  codec_ready
);
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_wr_data[8] && host_wr_data[1:0] != 2'd3 && !cmd_rd_data[8])
        |=> cmd_rd_data[8]);

    p_issue_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd_data[8] && frame_start) |=> (tx_valid && !cmd_rd_data[8]));

    p_read_slot_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_read) |-> (tx_data == 16'h0000));

    p_hold_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd_data[8] && !frame_start) |=> $stable(cmd_rd_data));

    p_timeout_fill_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[15]) |-> (rsp_rd_data[8] && rsp_rd_data[31:16] == 16'hFFFF));

    p_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_word[12:10] == ~$past(codec_ready)));

    p_bad_codec_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_wr_data[1:0] == 2'd3 && !cmd_rd_data[8] && !frame_start)
        |=> !cmd_rd_data[8]);
endmodule

bind codec_cmd_engine ccx_checker u_ccx_checker (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .cmd_rd_data(cmd_rd_data), .rsp_rd_data(rsp_rd_data), .stat_word(stat_word),
    .frame_start(frame_start), .tx_valid(tx_valid), .tx_read(tx_read),
    .tx_data(tx_data), .codec_ready(codec_ready)
);

// File: tb/codec_cmd_engine_tb_top.sv
module codec_cmd_engine_tb_top;
    localparam int TMO_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [TMO_W-1:0] tmo_frames = 4'd2;
    logic [31:0] cmd_rd_data, rsp_rd_data;
    logic [15:0] stat_word;
    logic        frame_start = 1'b0;
    logic        tx_valid, tx_read;
    logic [1:0]  tx_codec;
    logic [6:0]  tx_addr;
    logic [15:0] tx_data;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_codec = '0;
    logic [6:0]  rx_addr = '0;
    logic [15:0] rx_data = '0;
    logic [2:0]  codec_ready = 3'b111;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    codec_cmd_engine #(.TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .tmo_frames(tmo_frames), .cmd_rd_data(cmd_rd_data), .rsp_rd_data(rsp_rd_data),
        .stat_word(stat_word), .frame_start(frame_start), .tx_valid(tx_valid),
        .tx_codec(tx_codec), .tx_read(tx_read), .tx_addr(tx_addr), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_codec(rx_codec), .rx_addr(rx_addr), .rx_data(rx_data),
        .codec_ready(codec_ready)
    );

    function automatic logic [31:0] mk_cmd(input logic [1:0] c, input logic rd,
                                           input logic [6:0] a, input logic [15:0] d,
                                           input logic en);
        return {d, a, en, 5'b0, rd, c};
    endfunction

    function automatic logic [31:0] mk_rsp(input logic done, input logic [6:0] a,
                                           input logic [15:0] d);
        return {d, a, done, 8'h00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic reply(input logic [1:0] c, input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_codec = c; rx_addr = a; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic check_tx(input string req, input logic [1:0] c, input logic rd,
                            input logic [6:0] a, input logic [15:0] d);
        chk(req, {31'b0, tx_valid}, 32'd1);
        chk(req, {tx_data, tx_addr, tx_read, 6'b0, tx_codec},
            {rd ? 16'h0 : d, a, rd, 6'b0, c});
        chk(req, {31'b0, cmd_rd_data[8]}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] last_cmd;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {cmd_rd_data[8], rsp_rd_data[8], stat_word[15], tx_valid}, 32'd0);

        // R2 launch of a write
        host_write(mk_cmd(2'd1, 1'b0, 7'h26, 16'hBEEF, 1'b1));
        chk("R2", cmd_rd_data, mk_cmd(2'd1, 1'b0, 7'h26, 16'hBEEF, 1'b1));
        // R4 write while busy ignored
        host_write(mk_cmd(2'd2, 1'b1, 7'h11, 16'h1234, 1'b1));
        chk("R4", cmd_rd_data, mk_cmd(2'd1, 1'b0, 7'h26, 16'hBEEF, 1'b1));
        frame();
        check_tx("R3", 2'd1, 1'b0, 7'h26, 16'hBEEF);
        @(negedge clk);
        chk("R3", {31'b0, tx_valid}, 32'd0);
        chk("R11", {31'b0, rsp_rd_data[8]}, 32'd0);

        // R10 codec 3 and enable clear do nothing
        last_cmd = cmd_rd_data;
        host_write(mk_cmd(2'd3, 1'b1, 7'h05, 16'h5555, 1'b1));
        chk("R10", cmd_rd_data, last_cmd);
        host_write(mk_cmd(2'd0, 1'b1, 7'h05, 16'h5555, 1'b0));
        chk("R10", cmd_rd_data, last_cmd);

        // R5/R6 read with matching and mismatching replies
        tmo_frames = 4'd8;
        host_write(mk_cmd(2'd2, 1'b1, 7'h7C, 16'hAAAA, 1'b1));
        frame();
        check_tx("R3", 2'd2, 1'b1, 7'h7C, 16'hAAAA);
        reply(2'd2, 7'h7E, 16'h1111);
        chk("R6", rsp_rd_data, 32'd0);
        reply(2'd0, 7'h7C, 16'h2222);
        chk("R6", rsp_rd_data, 32'd0);
        reply(2'd2, 7'h7C, 16'h4D11);
        chk("R5", rsp_rd_data, mk_rsp(1'b1, 7'h7C, 16'h4D11));

        // R8 launch clears completion
        host_write(mk_cmd(2'd0, 1'b1, 7'h02, 16'h0, 1'b1));
        chk("R8", rsp_rd_data, 32'd0);

        // R7 timeout after three frames
        tmo_frames = 4'd3;
        frame();
        frame();
        frame();
        chk("R7", {31'b0, rsp_rd_data[8]}, 32'd0);
        frame();
        chk("R7", rsp_rd_data, mk_rsp(1'b1, 7'h02, 16'hFFFF));
        chk("R7", {31'b0, stat_word[15]}, 32'd1);
        host_write(mk_cmd(2'd1, 1'b1, 7'h10, 16'h0, 1'b1));
        chk("R8", {30'b0, stat_word[15], rsp_rd_data[8]}, 32'd0);

        // R7 limit zero acts as one frame
        tmo_frames = 4'd0;
        frame();
        frame();
        chk("R7", rsp_rd_data, mk_rsp(1'b1, 7'h10, 16'hFFFF));

        // R9 not-ready mirror
        @(negedge clk);
        codec_ready = 3'b101;
        @(negedge clk);
        chk("R9", {29'b0, stat_word[12:10]}, 32'd2);
        codec_ready = 3'b010;
        @(negedge clk);
        chk("R9", {29'b0, stat_word[12:10]}, 32'd5);
        codec_ready = 3'b111;

        // random transactions
        for (int n = 0; n < 40; n++) begin
            logic [1:0]  c;
            logic        rd;
            logic [6:0]  a;
            logic [15:0] d;
            logic [15:0] rdat;
            int          lim;
            c    = 2'($urandom_range(0, 2));
            rd   = 1'($urandom_range(0, 1));
            a    = 7'($urandom);
            d    = 16'($urandom);
            rdat = 16'($urandom);
            lim  = $urandom_range(1, 4);
            tmo_frames = 4'(lim);
            host_write(mk_cmd(c, rd, a, d, 1'b1));
            chk("R2", cmd_rd_data, mk_cmd(c, rd, a, d, 1'b1));
            frame();
            check_tx("R3", c, rd, a, d);
            if (!rd) begin
                chk("R11", {31'b0, rsp_rd_data[8]}, 32'd0);
            end else if ($urandom_range(0, 1) == 1) begin
                reply(c, a ^ 7'h01, rdat);
                chk("R6", {31'b0, rsp_rd_data[8]}, 32'd0);
                reply(c, a, rdat);
                chk("R5", rsp_rd_data, mk_rsp(1'b1, a, rdat));
            end else begin
                for (int f = 0; f < lim; f++) frame();
                chk("R7", rsp_rd_data, mk_rsp(1'b1, a, 16'hFFFF));
                chk("R7", {31'b0, stat_word[15]}, 32'd1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule